// File: doc/BRIEF.md
# Rejected Interrupt Replay Bitmap

This block records interrupts that the presenter rejects and replays them later. Each reject names an interrupt number. The block subtracts a programmable base from that number to get a source index below 2048. It then marks the source in a two-level bitmap: 32 words of 64 bits, plus a 32-bit summary that has one bit for each word that holds at least one marked source.

When a resend is requested, a scanner visits the summary from bit 0 upward and skips words that are empty. For each occupied word it takes the word's contents and clears both the word and its summary bit in the same cycle. It then issues one forced send per marked bit, lowest bit first, over a valid/ready channel toward the PQ gate. The scanner stalls while ready is low. A one-cycle done pulse closes every scan, including a scan that finds nothing. A reject that arrives during a scan is always stored. If its word has not been reached yet, the current scan replays it. If its word has already been taken, a later resend replays it.

Top module: `rbr_resender`

## Requirements
- R1: After reset the bitmap and summary are empty, `send_valid`, `scan_busy` and `scan_done` are low, and a first resend issues no send.
- R2: A reject with `rej_num` = `src_base` + s, where 0 <= s < 2048, marks source s: bit s[5:0] of word s[10:6] and summary bit s[10:6]. A later resend sends `send_src` = s.
- R3: A reject with `rej_num` below `src_base`, or with `rej_num` - `src_base` >= 2048, is ignored, and no later resend sends anything for it.
- R4: A resend whose summary is all zero sends nothing. `scan_done` is high in the cycle after the clock edge that samples `resend_req`.
- R5: A scan sends every marked source exactly once, in strictly ascending source order (word index first, then bit index), and leaves them cleared, so an immediate second resend sends nothing.
- R6: Repeated rejects of one source before a resend are merged and replayed once.
- R7: While `send_valid` is high and `send_ready` is low, `send_valid` stays high and `send_src` stays stable on the next cycle.
- R8: A reject that arrives during a scan is never lost. If its word has already been taken by the scan, it is replayed by the next resend and not by the current one.
- R9: `resend_req` is ignored while `scan_busy` is high. No second scan follows the current one.
- R10: `scan_done` is a single-cycle pulse after the last accepted send of a scan. `scan_busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_base | input | NUM_W | Interrupt number that maps to source 0 |
| rej_valid | input | 1 | Reject event strobe |
| rej_num | input | NUM_W | Interrupt number of the rejected interrupt |
| resend_req | input | 1 | Start a replay scan (accepted when idle) |
| send_valid | output | 1 | Forced send offered to the PQ gate |
| send_ready | input | 1 | PQ gate accepts the offered send |
| send_src | output | 11 | Source index of the offered send |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle pulse at scan completion |

## Verification
Internal faults in this block show up only at the replay port, and only when a resend runs. A summary bit that is dropped, or a word bit that is lost, appears as a source missing from the next scan. A bit that fails to clear appears as a duplicate on the immediate second resend. A wrong word or bit decode appears as a changed `send_src` value. Because of this, the checks compare every complete replay sequence with a bench-side bitmap model. The compare runs after directed corner sources and after random reject bursts under random backpressure, so any error is caught within one or two resends of the faulty reject.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
   typedef enum logic [1:0] {
      SCAN_IDLE  = 2'd0,
      SCAN_FETCH = 2'd1,
      SCAN_SEND  = 2'd2
   } scan_state_t;
endpackage

// File: rtl/rbr_ffs.sv
// Lowest-set-bit finder, used for both the summary and the word scan.
module rbr_ffs #(
   parameter int W = 32
) (
   input  logic [W-1:0]         vec,
   output logic                 found,
   output logic [$clog2(W)-1:0] idx
);
   localparam int IW = $clog2(W);

   initial begin
      assert (W >= 2) else $error("rbr_ffs: W must be at least 2");
   end

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/rbr_store.sv
// Two-level reject bitmap: per-word bits plus a summary of occupied words.
module rbr_store #(
   parameter int NUM_W  = 16,
   parameter int WORDS  = 32,
   parameter int WORD_W = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_W-1:0]           src_base,
   input  logic                       rej_valid,
   input  logic [NUM_W-1:0]           rej_num,
   input  logic                       take,
   input  logic [$clog2(WORDS)-1:0]   take_idx,
   output logic [WORDS-1:0]           summary,
   output logic [WORD_W-1:0]          take_word
);
   localparam int WIDX_W  = $clog2(WORDS);
   localparam int BIT_W   = $clog2(WORD_W);
   localparam int SRC_W   = WIDX_W + BIT_W;
   localparam int NUM_SRC = WORDS * WORD_W;

   logic [NUM_W:0]        diff;
   logic                  hit;
   logic [WIDX_W-1:0]     rej_w;
   logic [BIT_W-1:0]      rej_b;
   logic [WORD_W-1:0]     word_q [WORDS];
   logic [WORDS-1:0]      summ_q;

   assign diff  = {1'b0, rej_num} - {1'b0, src_base};
   assign hit   = rej_valid && !diff[NUM_W] && (diff < (NUM_W + 1)'(NUM_SRC));
   assign rej_w = diff[SRC_W-1:BIT_W];
   assign rej_b = diff[BIT_W-1:0];

   generate
      for (genvar g = 0; g < WORDS; g++) begin : g_word
         // The set follows the clear, so a reject that lands on the word being
         // taken in the same cycle survives for the next scan.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q[g] <= '0;
               summ_q[g] <= 1'b0;
            end else begin
               if (take && (take_idx == WIDX_W'(g))) begin
                  word_q[g] <= '0;
                  summ_q[g] <= 1'b0;
               end
               if (hit && (rej_w == WIDX_W'(g))) begin
                  word_q[g][rej_b] <= 1'b1;
                  summ_q[g]        <= 1'b1;
               end
            end
         end

         // An empty summary bit always means an empty word.
         assert_summary_covers_R8: assert property (
            @(posedge clk) disable iff (!rst_n)
            !summ_q[g] |-> (word_q[g] == '0));
      end
   endgenerate

   assign summary   = summ_q;
   assign take_word = word_q[take_idx];

   assert_reject_marks_R2: assert property (
      @(posedge clk) disable iff (!rst_n)
      hit |=> (summ_q[$past(rej_w)] && word_q[$past(rej_w)][$past(rej_b)]));
endmodule

// File: rtl/rbr_scan.sv
// Replay scanner: walks occupied words upward and offers one send per bit.
module rbr_scan
   import rbr_pkg::*;
#(
   parameter int WORDS  = 32,
   parameter int WORD_W = 64
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     resend_req,
   input  logic [WORDS-1:0]                         summary,
   input  logic [WORD_W-1:0]                        take_word,
   output logic                                     take,
   output logic [$clog2(WORDS)-1:0]                 take_idx,
   output logic                                     send_valid,
   input  logic                                     send_ready,
   output logic [$clog2(WORDS)+$clog2(WORD_W)-1:0]  send_src,
   output logic                                     busy,
   output logic                                     done
);
   localparam int WIDX_W = $clog2(WORDS);
   localparam int BIT_W  = $clog2(WORD_W);
   localparam int SRC_W  = WIDX_W + BIT_W;

   scan_state_t         st_q;
   logic [WIDX_W:0]     nxt_q;
   logic [WIDX_W-1:0]   cur_q;
   logic [WORD_W-1:0]   work_q;
   logic [WORDS-1:0]    ahead;
   logic                s_found;
   logic [WIDX_W-1:0]   s_idx;
   logic                b_found;
   logic [BIT_W-1:0]    b_idx;
   logic                fire;

   // Only words at or above the scan pointer are eligible, keeping order ascending.
   always_comb begin
      for (int i = 0; i < WORDS; i++) begin
         ahead[i] = summary[i] && ((WIDX_W + 1)'(i) >= nxt_q);
      end
   end

   rbr_ffs #(.W(WORDS))  u_sum_ffs (.vec(ahead),  .found(s_found), .idx(s_idx));
   rbr_ffs #(.W(WORD_W)) u_bit_ffs (.vec(work_q), .found(b_found), .idx(b_idx));

   assign take       = (st_q == SCAN_FETCH) && s_found;
   assign take_idx   = s_idx;
   assign send_valid = (st_q == SCAN_SEND) && b_found;
   assign send_src   = {cur_q, b_idx};
   assign fire       = send_valid && send_ready;
   assign busy       = (st_q != SCAN_IDLE);
   assign done       = (st_q == SCAN_FETCH) && !s_found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SCAN_IDLE;
         nxt_q  <= '0;
         cur_q  <= '0;
         work_q <= '0;
      end else begin
         unique case (st_q)
            SCAN_IDLE: begin
               if (resend_req) begin
                  st_q  <= SCAN_FETCH;
                  nxt_q <= '0;
               end
            end
            SCAN_FETCH: begin
               if (s_found) begin
                  cur_q  <= s_idx;
                  nxt_q  <= (WIDX_W + 1)'(s_idx) + (WIDX_W + 1)'(1);
                  work_q <= take_word;
                  st_q   <= SCAN_SEND;
               end else begin
                  st_q <= SCAN_IDLE;
               end
            end
            SCAN_SEND: begin
               if (!b_found) begin
                  st_q <= SCAN_FETCH;
               end else if (fire) begin
                  work_q[b_idx] <= 1'b0;
               end
            end
            default: st_q <= SCAN_IDLE;
         endcase
      end
   end

   // Ordering monitor for the ascending-order property.
   logic              seen_q;
   logic [SRC_W-1:0]  last_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         last_q <= '0;
      end else if (!busy) begin
         seen_q <= 1'b0;
      end else if (fire) begin
         seen_q <= 1'b1;
         last_q <= send_src;
      end
   end

   assert_ascending_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      (fire && seen_q) |-> (send_src > last_q));

   assert_send_held_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      (send_valid && !send_ready) |=> (send_valid && $stable(send_src)));

   assert_done_ends_R10: assert property (
      @(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));

   assert_no_restart_R9: assert property (
      @(posedge clk) disable iff (!rst_n)
      (busy && resend_req && !done) |=> busy);
endmodule

// File: rtl/rbr_resender.sv
module rbr_resender #(
   parameter int NUM_W  = 16,
   parameter int WORDS  = 32,
   parameter int WORD_W = 64
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [NUM_W-1:0]                         src_base,
   input  logic                                     rej_valid,
   input  logic [NUM_W-1:0]                         rej_num,
   input  logic                                     resend_req,
   output logic                                     send_valid,
   input  logic                                     send_ready,
   output logic [$clog2(WORDS)+$clog2(WORD_W)-1:0]  send_src,
   output logic                                     scan_busy,
   output logic                                     scan_done
);
   localparam int WIDX_W = $clog2(WORDS);
   localparam int BIT_W  = $clog2(WORD_W);
   localparam int SRC_W  = WIDX_W + BIT_W;

   initial begin
      assert ((WORDS >= 2) && ((WORDS & (WORDS - 1)) == 0))
         else $error("rbr_resender: WORDS must be a power of two");
      assert ((WORD_W >= 2) && ((WORD_W & (WORD_W - 1)) == 0))
         else $error("rbr_resender: WORD_W must be a power of two");
      assert (NUM_W > SRC_W)
         else $error("rbr_resender: NUM_W must exceed the source width");
   end

   logic [WORDS-1:0]   summary;
   logic [WORD_W-1:0]  take_word;
   logic               take;
   logic [WIDX_W-1:0]  take_idx;

   rbr_store #(.NUM_W(NUM_W), .WORDS(WORDS), .WORD_W(WORD_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_base  (src_base),
      .rej_valid (rej_valid),
      .rej_num   (rej_num),
      .take      (take),
      .take_idx  (take_idx),
      .summary   (summary),
      .take_word (take_word)
   );

   rbr_scan #(.WORDS(WORDS), .WORD_W(WORD_W)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .resend_req (resend_req),
      .summary    (summary),
      .take_word  (take_word),
      .take       (take),
      .take_idx   (take_idx),
      .send_valid (send_valid),
      .send_ready (send_ready),
      .send_src   (send_src),
      .busy       (scan_busy),
      .done       (scan_done)
   );

   assert_idle_quiet_R1: assert property (
      @(posedge clk) disable iff (!rst_n)
      !scan_busy |-> !send_valid);
endmodule

// File: tb/tb_rbr_resender.sv
module tb_rbr_resender;
   localparam int NUM_W = 16;
   localparam int NSRC  = 2048;
   localparam logic [NUM_W-1:0] BASE = 16'h0100;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_W-1:0]  src_base = BASE;
   logic              rej_valid = 1'b0;
   logic [NUM_W-1:0]  rej_num = '0;
   logic              resend_req = 1'b0;
   logic              send_valid;
   logic              send_ready = 1'b0;
   logic [10:0]       send_src;
   logic              scan_busy;
   logic              scan_done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [NSRC-1:0] model = '0;

   always #2 clk = ~clk;

   rbr_resender #(.NUM_W(NUM_W)) dut (
      .clk(clk), .rst_n(rst_n), .src_base(src_base), .rej_valid(rej_valid),
      .rej_num(rej_num), .resend_req(resend_req), .send_valid(send_valid),
      .send_ready(send_ready), .send_src(send_src), .scan_busy(scan_busy),
      .scan_done(scan_done));

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic bit in_range(input int num);
      return (num >= int'(BASE)) && (num - int'(BASE) < NSRC);
   endfunction

   task automatic reject(input int num);
      rej_valid = 1'b1;
      rej_num   = NUM_W'(num);
      if (in_range(num)) model[num - int'(BASE)] = 1'b1;
      @(negedge clk);
      rej_valid = 1'b0;
   endtask

   // Runs one resend scan and compares the replay with the model.
   task automatic do_resend(input int ready_pct, input int inj, input bit again,
                            input string rq);
      int exp_q[$];
      int got_q[$];
      bit pv = 0, pr = 0, injected = 0, saw_done = 0;
      int psrc = 0;
      for (int i = 0; i < NSRC; i++) if (model[i]) exp_q.push_back(i);
      model = '0;
      resend_req = 1'b1;
      @(negedge clk);
      resend_req = 1'b0;
      if (exp_q.size() == 0) begin
         chk(scan_done && !send_valid, "R4", "empty scan done next cycle",
             int'(scan_done), 1);
      end
      for (int cyc = 0; cyc < 20000; cyc++) begin
         bit r;
         rej_valid  = 1'b0;
         resend_req = 1'b0;
         if (scan_done) begin
            saw_done = 1;
            break;
         end
         if (pv && !pr) begin
            chk(send_valid && (int'(send_src) == psrc), "R7", "stalled send held",
                int'(send_src), psrc);
         end
         r = (($urandom % 100) < ready_pct);
         send_ready = r;
         if (send_valid && r) begin
            got_q.push_back(int'(send_src));
            if (inj >= 0 && !injected) begin
               injected   = 1;
               rej_valid  = 1'b1;
               rej_num    = NUM_W'(int'(BASE) + inj);
               resend_req = again;
            end
         end
         pv = send_valid; pr = r; psrc = int'(send_src);
         @(negedge clk);
      end
      rej_valid  = 1'b0;
      resend_req = 1'b0;
      send_ready = 1'b0;
      chk(saw_done, "R10", "scan reached done", int'(saw_done), 1);
      chk(got_q.size() == exp_q.size(), rq, "replay count", got_q.size(), exp_q.size());
      for (int k = 0; k < exp_q.size() && k < got_q.size(); k++) begin
         chk(got_q[k] == exp_q[k], rq, "replayed source", got_q[k], exp_q[k]);
      end
      @(negedge clk);
      chk(!scan_done && !scan_busy, "R10", "done is one cycle",
          int'(scan_done) + 2 * int'(scan_busy), 0);
      if (again) begin
         bit quiet = 1;
         for (int c = 0; c < 4; c++) begin
            if (scan_busy || send_valid) quiet = 0;
            @(negedge clk);
         end
         chk(quiet, "R9", "mid-scan request ignored", int'(quiet), 1);
      end
      if (injected) model[inj] = 1'b1;
   endtask

   function automatic int pick_src();
      int sel = $urandom % 8;
      case (sel)
         0: return 0;
         1: return 63;
         2: return 64;
         3: return NSRC - 1;
         4: return NSRC - 64;
         default: return $urandom % NSRC;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(!send_valid && !scan_busy && !scan_done, "R1", "outputs in reset",
          int'(send_valid) + int'(scan_busy) + int'(scan_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R4: empty after reset
      do_resend(100, -1, 0, "R1");

      // R2: basic offset mapping
      reject(int'(BASE) + 5);
      do_resend(100, -1, 0, "R2");

      // R3: out-of-range rejects are dropped
      reject(int'(BASE) - 1);
      reject(int'(BASE) + NSRC);
      reject(0);
      reject(int'(BASE) + 700);
      do_resend(100, -1, 0, "R3");

      // R5: boundary sources, ascending, then cleared
      reject(int'(BASE) + NSRC - 1);
      reject(int'(BASE) + 64);
      reject(int'(BASE) + 0);
      reject(int'(BASE) + NSRC - 64);
      reject(int'(BASE) + 63);
      do_resend(50, -1, 0, "R5");
      do_resend(100, -1, 0, "R5");

      // R6: duplicates merge
      reject(int'(BASE) + 130);
      reject(int'(BASE) + 130);
      reject(int'(BASE) + 130);
      do_resend(100, -1, 0, "R6");

      // R8 + R9: reject into a taken word and a request during the scan
      reject(int'(BASE) + 3);
      reject(int'(BASE) + 9);
      reject(int'(BASE) + 1500);
      do_resend(30, 1, 1, "R8");
      do_resend(100, -1, 0, "R8");

      // Random bursts under random backpressure (R2, R3, R5, R7)
      for (int rnd = 0; rnd < 12; rnd++) begin
         int n = $urandom % 40;
         for (int j = 0; j < n; j++) begin
            if (($urandom % 10) == 0) reject(int'(BASE) + NSRC + ($urandom % 50));
            else reject(int'(BASE) + pick_src());
         end
         do_resend(20 + ($urandom % 81), -1, 0, "R5");
      end
      do_resend(100, -1, 0, "R5");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule